// File: doc/BRIEF.md
# Serial Preamble and Start-Delimiter Detector

This block sits on a one-bit receive line, one bit per clock, qualified by a receive-data-valid input. Each time data-valid goes high, it counts bit times. It skips a fixed run of leading bits. It then requires the next few bits to strictly alternate. After that it hunts for a pair of ones, which marks the start delimiter. When the header checks out, it raises a one-cycle frame-start pulse. It then forwards every later bit of the frame on a strobed output, and it never forwards any header bit.

A broken header raises a one-cycle reject pulse. The frame is then ignored until data-valid drops. The detector re-arms on every falling edge of data-valid. A frame enable input can suppress everything: while it is low, the block produces no frame-start, no data and no reject. A frame interrupted that way stays ignored until data-valid drops. Address filtering and CRC checking belong to later stages.

Two parameters size the header schedule. `BLIND_BITS` (default 16) is the length of the skipped window. `ALT_BITS` (default 5) is the length of the strict-alternation window. With the defaults, bit times 1 to 16 are skipped, bit times 17 to 21 must alternate, and the delimiter hunt starts at bit time 22. Bit time 1 is the first clock with data-valid high. All outputs are registered: an output caused by the bit sampled at one clock edge appears after that edge and holds for one cycle.

Top module: `preamble_sfd_detector`

## Requirements
- R1: After reset, out_vld, out_bit, sof and rej are all 0.
- R2: The values of bit times 1 to BLIND_BITS never cause a reject, a frame start or a forwarded bit, even when they contain 00 or 11 pairs.
- R3: In the alternation window, bit time BLIND_BITS+1 is only recorded. If a later bit up to bit time BLIND_BITS+ALT_BITS equals the bit before it, rej pulses for one cycle after that bit.
- R4: After bit time BLIND_BITS+ALT_BITS, the first 11 pair pulses sof for one cycle after its second 1. The pair may start with the last alternation bit.
- R5: During the delimiter hunt, a 00 pair pulses rej for one cycle after its second 0, and no sof follows.
- R6: Every bit after the delimiter appears on out_bit with out_vld = 1 one cycle after it is sampled. Header bits never appear with out_vld = 1.
- R7: The bit-time count saturates once the hunt begins, so alternating preambles of any length are accepted.
- R8: After a reject, the block produces no sof, rej or out_vld until rx_dv falls. The next rise of rx_dv starts a fresh header check.
- R9: While en is low, no sof, rej or out_vld is produced, and the current frame stays ignored until rx_dv falls, even if en returns high.
- R10: out_vld is 0 in the cycle after a clock at which rx_dv was low, so a data-valid drop ends forwarding at once.
- R11: sof and rej are never high together and are never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit time per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Receive enable |
| rx_dv | input | 1 | Receive data valid |
| rx_d | input | 1 | Serial receive bit |
| out_bit | output | 1 | Forwarded frame bit |
| out_vld | output | 1 | out_bit carries a frame bit |
| sof | output | 1 | Header accepted, one-cycle pulse |
| rej | output | 1 | Header rejected, one-cycle pulse |

## Verification
The bench uses the default parameters: a 16-bit skipped window and a 5-bit alternation window. With these values every schedule boundary can be reached with short frames: bit times 16, 17, 18, 21, 22 and 23. The stimulus puts equal pairs at both edges of the alternation window. It completes the delimiter on the pair formed by bit times 21 and 22, and it runs an alternating preamble far past the saturation point of the counter. Each scenario also checks that data-valid and enable gating ends or blocks forwarding within one cycle.

// File: rtl/preamble_sfd_detector.sv
module preamble_sfd_detector #(
  parameter int BLIND_BITS = 16,
  parameter int ALT_BITS   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rx_dv,
  input  logic rx_d,
  output logic out_bit,
  output logic out_vld,
  output logic sof,
  output logic rej
);
  localparam int LAST_ALT = BLIND_BITS + ALT_BITS;
  localparam int CNT_W    = $clog2(LAST_ALT + 1);
  localparam logic [CNT_W-1:0] BLIND_C = CNT_W'(BLIND_BITS);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(LAST_ALT);

  typedef enum logic [1:0] {ST_HDR, ST_DATA, ST_DROP} st_t;

  st_t             st;
  logic [CNT_W-1:0] cnt;
  logic             prev;

  wire active   = rx_dv && en && (st == ST_HDR);
  wire in_alt   = (cnt > BLIND_C) && (cnt < LAST_C);
  wire hunting  = (cnt == LAST_C);
  wire pair_eq  = (rx_d == prev);
  wire hit_sof  = active && hunting && pair_eq && rx_d;
  wire hit_rej  = active && pair_eq && (in_alt || (hunting && !rx_d));
  wire fwd      = rx_dv && en && (st == ST_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_HDR;
      cnt     <= '0;
      prev    <= 1'b0;
      out_bit <= 1'b0;
      out_vld <= 1'b0;
      sof     <= 1'b0;
      rej     <= 1'b0;
    end else begin
      out_vld <= fwd;
      out_bit <= fwd && rx_d;
      sof     <= hit_sof;
      rej     <= hit_rej;
      if (!rx_dv) begin
        st  <= ST_HDR;
        cnt <= '0;
      end else if (!en) begin
        st <= ST_DROP;
      end else if (st == ST_HDR) begin
        prev <= rx_d;
        if (!hunting) cnt <= cnt + 1'b1;
        if (hit_sof)      st <= ST_DATA;
        else if (hit_rej) st <= ST_DROP;
      end
    end
  end

  AST_SOF_REJ_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(sof && rej)); // R11
  AST_SOF_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) sof |=> !sof); // R11
  AST_REJ_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) rej |=> !rej); // R11
  AST_EN_GATE:      assert property (@(posedge clk) disable iff (!rst_n) !en |=> (!sof && !rej && !out_vld)); // R9
  AST_DV_GATE:      assert property (@(posedge clk) disable iff (!rst_n) !rx_dv |=> !out_vld); // R10
  AST_REJ_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) rej |=> (!out_vld && !sof)); // R8
  AST_SOF_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n) sof |-> !out_vld); // R6
  AST_CNT_RANGE:    assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST_C); // R7
endmodule

// File: tb/preamble_sfd_detector_tb_top.sv
module preamble_sfd_detector_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, rx_dv = 1'b0, rx_d = 1'b0;
  logic out_bit, out_vld, sof, rej;
  int tests = 0, fails = 0;

  int mode = 0, bt = 0, pb = 0;
  logic e_vld, e_bit, e_sof, e_rej;

  always #2 clk = ~clk;

  preamble_sfd_detector dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_dv(rx_dv), .rx_d(rx_d),
    .out_bit(out_bit), .out_vld(out_vld), .sof(sof), .rej(rej)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", what, act, exp, $time);
    end
  endtask

  task automatic model(input logic dv, input logic e, input logic d);
    e_vld = 0; e_bit = 0; e_sof = 0; e_rej = 0;
    if (!dv) begin mode = 0; bt = 0; end
    else if (!e) mode = 2;
    else if (mode == 1) begin e_vld = 1; e_bit = d; end
    else if (mode == 0) begin
      bt++;
      if (bt > 17 && bt <= 21 && int'(d) == pb) begin e_rej = 1; mode = 2; end
      else if (bt > 21 && int'(d) == pb) begin
        if (d) begin e_sof = 1; mode = 1; end
        else begin e_rej = 1; mode = 2; end
      end
      pb = int'(d);
    end
  endtask

  task automatic cyc(input logic dv, input logic e, input logic d);
    rx_dv = dv; en = e; rx_d = d;
    model(dv, e, d);
    @(posedge clk);
    @(negedge clk);
    chk(sof, e_sof, "R4 sof");
    chk(rej, e_rej, "R3/R5/R8 rej");
    chk(out_vld, e_vld, "R6/R9/R10 out_vld");
    if (e_vld) chk(out_bit, e_bit, "R6 out_bit");
  endtask

  task automatic bits(input logic [63:0] v, input int n, input logic e = 1'b1);
    for (int i = 0; i < n; i++) cyc(1'b1, e, v[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sof, 1'b0, "R1 sof reset");
    chk(rej, 1'b0, "R1 rej reset");
    chk(out_vld, 1'b0, "R1 out_vld reset");
    chk(out_bit, 1'b0, "R1 out_bit reset");
    rst_n = 1'b1;
    idle(2);
    // R2 blind junk with equal pairs, R4 delimiter on bits 21/22, R6 data
    bits(64'hF00F, 16); bits(64'b10101, 5); bits(64'b1, 1); bits(64'hA5, 8); idle(2);
    // R7 long alternating preamble then 11
    bits(64'h0000, 16); bits(64'h5555_5555_5555, 48); bits(64'b11, 2); bits(64'h3C, 8); idle(2);
    // R3 equal pair at bits 17/18
    bits(64'hFFFF, 16); bits(64'b11, 2); bits(64'hFF0F, 16); idle(2);
    // R3 equal pair at bits 20/21
    bits(64'h1234, 16); bits(64'b00101, 5); bits(64'b1111, 4); idle(2);
    // R5 00 pair in hunt at bits 22/23, R8 stays ignored
    bits(64'hAAAA, 16); bits(64'b10101, 5); bits(64'b00, 2); bits(64'hFFFF, 16); idle(1);
    // R8 re-arm: good frame right after
    bits(64'h0, 16); bits(64'b0101010, 7); bits(64'b1, 1); bits(64'h96, 8); idle(1);
    // R9 enable low mid-preamble then high again: stays ignored
    bits(64'h0, 10); bits(64'h0, 3, 1'b0); bits(64'h0, 3); bits(64'b1010101011, 10); idle(1);
    // R9 enable low during data
    bits(64'h0, 16); bits(64'b1010101, 7); bits(64'b1, 1); bits(64'h5A, 4); bits(64'hF, 2, 1'b0); bits(64'hFF, 6); idle(1);
    // R10 dv drop mid data then fresh frame
    bits(64'h0, 16); bits(64'b10101, 5); bits(64'b1, 1); bits(64'hC3, 5); idle(1);
    bits(64'h0, 16); bits(64'b01010, 5); bits(64'b1, 1); bits(64'b11, 2); bits(64'h71, 7); idle(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule